// File: doc/BRIEF.md
# Memory Soft-Error CRC Monitor

This block guards a small on-chip configuration memory against soft errors. It runs on a free-running detection clock and scans the memory without stopping. Each detection cycle it folds one 32-bit word into a running CRC-32. At the end of every pass it compares the result with a golden CRC, which is derived at elaboration from the memory's initial image. If the two differ, it raises a sticky error flag. A one-cycle pulse marks the end of every pass.

Software or a host reads values back through a 32-bit serial readout register clocked by a separate user clock. The host chooses what the register loads: the golden CRC or the most recent pass signature. It then clocks the bits out MSB first. Each finished signature reaches the user domain through a request/acknowledge toggle handshake, so a parallel load never captures a value that is still changing. A test input can flip any single memory bit to inject an error.

The detection engine is a three-state machine:
- SEED starts the running CRC after reset.
- SCAN steps one word per cycle.
- WRAP publishes the signature and the verdict, then reseeds.

Its transitions are:
- SEED to SCAN, always.
- SCAN to SCAN, until the last word.
- SCAN to WRAP, on the last word.
- WRAP to SCAN, always.

Top module: `crc_mem_monitor`

## Requirements
- R1: While `rd_shift` is 0, every rising `usr_clk` edge loads the 32-bit readout register in parallel. Holding `rd_shift` low reloads it on each edge.
- R2: On a load, `rd_src`=0 selects the golden CRC and `rd_src`=1 selects the latest signature delivered to the user domain.
- R3: While `rd_shift` is 1, `rd_src` has no effect on the readout register or on `rd_bit`.
- R4: While `rd_shift` is 1, the register moves one place toward its MSB per `usr_clk` and a 0 enters at bit 0. `rd_bit` is always the register's bit 31, so after a load the word appears MSB first and is complete after 31 further clocks.
- R5: The CRC is built as follows.
  - The generator polynomial is 0x04C11DB7 and the running value starts at 0xFFFFFFFF.
  - Words enter MSB first, with no reflection and no final inversion.
  - Memory word i starts as (i*0x9E3779B9) XOR `SALT`, modulo 2^32.
  - The golden CRC is the CRC of that initial image, taken in address order 0..DEPTH-1.
- R6: `pass_done` is high for exactly one `det_clk` cycle per pass. The first pulse follows the (DEPTH+2)-th rising edge after `det_rst` is released, and later pulses come every DEPTH+1 cycles.
- R7: `crc_err` rises together with a `pass_done` pulse whose pass CRC differs from the golden CRC. Once high, it stays high until `det_rst`, even after the memory is repaired.
- R8: The signature changes only at the end of a pass. A signature that has reached the user domain always equals the CRC of one complete pass.
- R9: `det_rst` (synchronous) clears `crc_err` and `pass_done` and restores the initial memory image. `usr_rst` (synchronous) clears the readout register, so `rd_bit` is 0.
- R10: A `det_clk` edge with `inj_en` high inverts bit `inj_bit` of word `inj_addr`. Addresses of DEPTH or above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| det_clk | input | 1 | Free-running detection clock |
| det_rst | input | 1 | Synchronous reset, detection domain |
| usr_clk | input | 1 | User readout clock |
| usr_rst | input | 1 | Synchronous reset, user domain |
| inj_en | input | 1 | Flip one memory bit this detection cycle |
| inj_addr | input | AW | Word to flip |
| inj_bit | input | 5 | Bit within the word to flip |
| rd_shift | input | 1 | 1 = shift readout register, 0 = parallel load |
| rd_src | input | 1 | Load source: 0 golden CRC, 1 signature |
| rd_bit | output | 1 | Serial readout, MSB of the readout register |
| crc_err | output | 1 | Sticky mismatch flag (detection domain) |
| pass_done | output | 1 | One-cycle end-of-pass pulse (detection domain) |

## Verification
The scan is first run on the untouched image, where the signature must read back equal to the golden CRC. A single bit is then flipped in a middle word, which must change the signature and set the flag. The same bit is flipped back, which shows that the signature recovers while the flag stays set. A flip of bit 31 in the last word exercises the final SCAN step and the highest bit. Readouts are taken from both load sources, with `rd_src` toggling during shifts and with loads held for several cycles, which separates a correct load and shift from a stale or mis-ordered one.

// File: rtl/crc_mem_monitor_pkg.sv
`timescale 1ns/1ps
package crc_mem_monitor_pkg;
    localparam int          WORD_W   = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ENG_SEED = 2'd0,
        ENG_SCAN = 2'd1,
        ENG_WRAP = 2'd2
    } eng_state_t;

    // One 32-bit word folded into the CRC, MSB first, bit-serial form unrolled.
    function automatic logic [31:0] crc_fold(input logic [31:0] c_in, input logic [31:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int b = 31; b >= 0; b--) begin
            fb = c[31] ^ d[b];
            c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return c;
    endfunction

    function automatic logic [31:0] word_init(input int idx, input logic [31:0] salt);
        return (32'(idx) * 32'h9E37_79B9) ^ salt;
    endfunction

    function automatic logic [31:0] image_crc(input int depth, input logic [31:0] salt);
        logic [31:0] c;
        c = CRC_SEED;
        for (int i = 0; i < depth; i++) c = crc_fold(c, word_init(i, salt));
        return c;
    endfunction
endpackage

// File: rtl/crc_mem_monitor_store.sv
`timescale 1ns/1ps
module crc_mem_monitor_store
    import crc_mem_monitor_pkg::*;
#(
    parameter int          DEPTH = 16,
    parameter logic [31:0] SALT  = 32'hA5A5_A5A5,
    localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flip_en,
    input  logic [AW-1:0]     flip_addr,
    input  logic [4:0]        flip_bit,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                cells[i] <= word_init(i, SALT);
            end else if (flip_en && (flip_addr == AW'(i))) begin
                cells[i] <= cells[i] ^ (WORD_W'(1) << flip_bit);
            end
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/crc_mem_monitor_engine.sv
`timescale 1ns/1ps
module crc_mem_monitor_engine
    import crc_mem_monitor_pkg::*;
#(
    parameter int          DEPTH  = 16,
    parameter logic [31:0] GOLDEN = 32'h0,
    localparam int         AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] sig,
    output logic              done,
    output logic              err
);
    eng_state_t        state, state_nx;
    logic [WORD_W-1:0] acc;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ENG_SEED;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_SEED: state_nx = ENG_SCAN;
            ENG_SCAN: if (addr == LAST) state_nx = ENG_WRAP;
            ENG_WRAP: state_nx = ENG_SCAN;
            default:  state_nx = ENG_SEED;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= CRC_SEED;
            addr <= '0;
            sig  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ENG_SEED: begin
                    acc  <= CRC_SEED;
                    addr <= '0;
                end
                ENG_SCAN: begin
                    acc  <= crc_fold(acc, word);
                    addr <= (addr == LAST) ? '0 : addr + AW'(1);
                end
                ENG_WRAP: begin
                    sig  <= acc;
                    done <= 1'b1;
                    if (acc != GOLDEN) err <= 1'b1;
                    acc  <= CRC_SEED;
                    addr <= '0;
                end
                default: begin
                    acc  <= CRC_SEED;
                    addr <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/crc_mem_monitor_xfer.sv
`timescale 1ns/1ps
module crc_mem_monitor_xfer
    import crc_mem_monitor_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_new,
    input  logic [WORD_W-1:0] src_word,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic [WORD_W-1:0] dst_word
);
    logic [WORD_W-1:0]      snap;
    logic                   req, fresh, ack_tog;
    logic [SYNC_STAGES-1:0] ack_sync, req_sync;
    logic                   idle;

    assign idle = (req == ack_sync[SYNC_STAGES-1]);

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            snap     <= '0;
            req      <= 1'b0;
            fresh    <= 1'b0;
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tog};
            if (idle && (fresh || src_new)) begin
                snap  <= src_word;
                req   <= ~req;
                fresh <= 1'b0;
            end else if (src_new) begin
                fresh <= 1'b1;
            end
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            req_sync <= '0;
            ack_tog  <= 1'b0;
            dst_word <= '0;
        end else begin
            req_sync <= {req_sync[SYNC_STAGES-2:0], req};
            if (req_sync[SYNC_STAGES-1] != ack_tog) begin
                dst_word <= snap;
                ack_tog  <= req_sync[SYNC_STAGES-1];
            end
        end
    end
endmodule

// File: rtl/crc_mem_monitor_readout.sv
`timescale 1ns/1ps
module crc_mem_monitor_readout
    import crc_mem_monitor_pkg::*;
#(
    parameter logic [31:0] GOLDEN = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              src,
    input  logic [WORD_W-1:0] sig,
    output logic [WORD_W-1:0] sreg,
    output logic              sbit
);
    always_ff @(posedge clk) begin
        if (rst)         sreg <= '0;
        else if (!shift) sreg <= src ? sig : GOLDEN;
        else             sreg <= {sreg[WORD_W-2:0], 1'b0};
    end

    assign sbit = sreg[WORD_W-1];
endmodule

// File: rtl/crc_mem_monitor.sv
`timescale 1ns/1ps
module crc_mem_monitor
    import crc_mem_monitor_pkg::*;
#(
    parameter int          DEPTH = 16,
    parameter logic [31:0] SALT  = 32'hA5A5_A5A5,
    localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          det_clk,
    input  logic          det_rst,
    input  logic          usr_clk,
    input  logic          usr_rst,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_addr,
    input  logic [4:0]    inj_bit,
    input  logic          rd_shift,
    input  logic          rd_src,
    output logic          rd_bit,
    output logic          crc_err,
    output logic          pass_done
);
    localparam logic [31:0] GOLDEN_CRC = image_crc(DEPTH, SALT);

    logic [AW-1:0]     scan_addr;
    logic [WORD_W-1:0] scan_word, sig_q, sig_usr, ro_reg;

    crc_mem_monitor_store #(.DEPTH(DEPTH), .SALT(SALT)) u_store (
        .clk(det_clk), .rst(det_rst),
        .flip_en(inj_en), .flip_addr(inj_addr), .flip_bit(inj_bit),
        .raddr(scan_addr), .rdata(scan_word)
    );

    crc_mem_monitor_engine #(.DEPTH(DEPTH), .GOLDEN(GOLDEN_CRC)) u_engine (
        .clk(det_clk), .rst(det_rst), .word(scan_word), .addr(scan_addr),
        .sig(sig_q), .done(pass_done), .err(crc_err)
    );

    crc_mem_monitor_xfer #(.SYNC_STAGES(2)) u_xfer (
        .src_clk(det_clk), .src_rst(det_rst), .src_new(pass_done), .src_word(sig_q),
        .dst_clk(usr_clk), .dst_rst(usr_rst), .dst_word(sig_usr)
    );

    crc_mem_monitor_readout #(.GOLDEN(GOLDEN_CRC)) u_readout (
        .clk(usr_clk), .rst(usr_rst), .shift(rd_shift), .src(rd_src),
        .sig(sig_usr), .sreg(ro_reg), .sbit(rd_bit)
    );
endmodule

// File: rtl/crc_mem_monitor_chk.sv
`timescale 1ns/1ps
module crc_mem_monitor_chk #(
    parameter int          DEPTH = 16,
    parameter logic [31:0] SALT  = 32'hA5A5_A5A5
) (
    input logic        det_clk,
    input logic        det_rst,
    input logic        usr_clk,
    input logic        usr_rst,
    input logic        rd_shift,
    input logic        rd_src,
    input logic        pass_done,
    input logic        crc_err,
    input logic [31:0] ro_reg,
    input logic [31:0] sig_q,
    input logic [31:0] sig_usr
);
    localparam logic [31:0] GOLD = crc_mem_monitor_pkg::image_crc(DEPTH, SALT);

    AST_DONE_ONE_CYCLE: assert property (@(posedge det_clk) disable iff (det_rst)
        pass_done |=> !pass_done); // R6
    AST_ERR_STICKY: assert property (@(posedge det_clk) disable iff (det_rst)
        crc_err |=> crc_err); // R7
    AST_ERR_RISES_AT_PASS: assert property (@(posedge det_clk) disable iff (det_rst)
        $rose(crc_err) |-> pass_done); // R7
    AST_SIG_ONLY_AT_PASS: assert property (@(posedge det_clk) disable iff (det_rst)
        !$stable(sig_q) |-> pass_done); // R8
    AST_LOAD_GOLDEN: assert property (@(posedge usr_clk) disable iff (usr_rst)
        (!rd_shift && !rd_src) |=> (ro_reg == GOLD)); // R2
    AST_LOAD_SIG: assert property (@(posedge usr_clk) disable iff (usr_rst)
        (!rd_shift && rd_src) |=> (ro_reg == $past(sig_usr))); // R1
    AST_SHIFT_STEP: assert property (@(posedge usr_clk) disable iff (usr_rst)
        rd_shift |=> (ro_reg == {$past(ro_reg[30:0]), 1'b0})); // R4
endmodule

bind crc_mem_monitor crc_mem_monitor_chk #(.DEPTH(DEPTH), .SALT(SALT)) u_chk (
    .det_clk(det_clk), .det_rst(det_rst), .usr_clk(usr_clk), .usr_rst(usr_rst),
    .rd_shift(rd_shift), .rd_src(rd_src), .pass_done(pass_done), .crc_err(crc_err),
    .ro_reg(ro_reg), .sig_q(sig_q), .sig_usr(sig_usr)
);

// File: tb/crc_mem_monitor_test.sv
`timescale 1ns/1ps
module crc_mem_monitor_test;
    localparam int          DEPTH = 16;
    localparam int          AW    = $clog2(DEPTH);
    localparam logic [31:0] SALT  = 32'hA5A5_A5A5;

    logic det_clk = 0, usr_clk = 0;
    logic det_rst = 1, usr_rst = 1;
    logic inj_en = 0;
    logic [AW-1:0] inj_addr = '0;
    logic [4:0] inj_bit = '0;
    logic rd_shift = 1, rd_src = 0;
    logic rd_bit, crc_err, pass_done;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #7  det_clk = ~det_clk;
    always #10 usr_clk = ~usr_clk;   // 50 MHz

    crc_mem_monitor #(.DEPTH(DEPTH), .SALT(SALT)) uut (
        .det_clk(det_clk), .det_rst(det_rst), .usr_clk(usr_clk), .usr_rst(usr_rst),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
        .rd_shift(rd_shift), .rd_src(rd_src), .rd_bit(rd_bit),
        .crc_err(crc_err), .pass_done(pass_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural CRC: xor the word in, then 32 polynomial steps
    function automatic logic [31:0] m_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c ^ d;
        for (int k = 0; k < 32; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    function automatic logic [31:0] m_init(input int i);
        return (32'(i) * 32'h9E37_79B9) ^ SALT;
    endfunction

    // CRC of the initial image with up to one flipped bit (fa < 0: none)
    function automatic logic [31:0] img_crc(input int fa, input int fb);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < DEPTH; i++) begin
            logic [31:0] w = m_init(i);
            if (i == fa) w[fb] = ~w[fb];
            c = m_step(c, w);
        end
        return c;
    endfunction

    logic [31:0] gold_m;
    initial gold_m = img_crc(-1, 0);

    // detection-domain reference model
    logic [31:0] mem_m [DEPTH];
    logic [31:0] acc_m = 0, sig_m = 0;
    int  pos_m = -1;
    logic done_m = 0, err_m = 0;
    bit det_started = 0;

    always @(posedge det_clk) begin
        det_started <= 1;
        if (det_rst) begin
            pos_m <= -1; acc_m <= 32'hFFFF_FFFF; done_m <= 0; err_m <= 0; sig_m <= 0;
            for (int i = 0; i < DEPTH; i++) mem_m[i] <= m_init(i);
        end else begin
            done_m <= 0;
            if (inj_en && int'(inj_addr) < DEPTH) mem_m[inj_addr][inj_bit] <= ~mem_m[inj_addr][inj_bit];
            if (pos_m < 0) begin
                acc_m <= 32'hFFFF_FFFF; pos_m <= 0;
            end else if (pos_m < DEPTH) begin
                acc_m <= m_step(acc_m, mem_m[pos_m]); pos_m <= pos_m + 1;
            end else begin
                sig_m <= acc_m; done_m <= 1;
                if (acc_m != gold_m) err_m <= 1;
                acc_m <= 32'hFFFF_FFFF; pos_m <= 0;
            end
        end
    end

    always @(negedge det_clk) if (det_started && !finished) begin
        chk(pass_done === done_m, "R6 pass_done", 32'(pass_done), 32'(done_m));
        chk(crc_err === err_m, "R7 crc_err", 32'(crc_err), 32'(err_m));
    end

    // user-domain reference model
    logic [31:0] sig_known = 0, sr_m = 0;
    bit usr_started = 0;
    always @(posedge usr_clk) begin
        usr_started <= 1;
        if (usr_rst)       sr_m <= 0;
        else if (!rd_shift) sr_m <= rd_src ? sig_known : gold_m;
        else               sr_m <= {sr_m[30:0], 1'b0};
    end

    always @(negedge usr_clk) if (usr_started && !finished)
        chk(rd_bit === sr_m[31], "R1/R3/R4 rd_bit", 32'(rd_bit), 32'(sr_m[31]));

    task automatic read_word(input logic src, output logic [31:0] w);
        @(negedge usr_clk); rd_shift = 0; rd_src = src;
        @(negedge usr_clk); w[31] = rd_bit; rd_shift = 1;
        for (int i = 30; i >= 0; i--) begin
            rd_src = i[0];          // R3: toggled while shifting
            @(negedge usr_clk); w[i] = rd_bit;
        end
        rd_src = 0;
    endtask

    task automatic settle();
        repeat (5 * (DEPTH + 1)) @(negedge det_clk);
        repeat (12) @(negedge usr_clk);
        sig_known = sig_m;
    endtask

    task automatic inject(input int a, input int b);
        @(negedge det_clk); inj_en = 1; inj_addr = AW'(a); inj_bit = 5'(b);
        @(negedge det_clk); inj_en = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int n;
        repeat (3) @(negedge det_clk);
        chk(crc_err === 0 && pass_done === 0, "R9 reset det outputs", {crc_err, pass_done}, 0);
        @(negedge usr_clk);
        chk(rd_bit === 0, "R9 reset rd_bit", 32'(rd_bit), 0);
        usr_rst = 0;
        @(negedge det_clk); det_rst = 0;
        n = 0;
        do begin @(negedge det_clk); n++; end while (!pass_done && n < 100);
        chk(n == DEPTH + 2, "R6 first pass latency", n, DEPTH + 2);

        settle();
        read_word(0, w);
        chk(w == gold_m, "R2/R5 golden readout", w, gold_m);
        read_word(1, w);
        chk(w == gold_m, "R8/R5 clean signature", w, gold_m);
        chk(crc_err === 0, "R7 no error on clean image", 32'(crc_err), 0);

        // R1: load held low for several clocks, then shifted
        @(negedge usr_clk); rd_shift = 0; rd_src = 1;
        repeat (3) @(negedge usr_clk);
        rd_src = 0;
        @(negedge usr_clk); rd_shift = 1;
        chk(rd_bit === gold_m[31], "R1 reload with held load", 32'(rd_bit), 32'(gold_m[31]));
        repeat (32) @(negedge usr_clk);
        chk(rd_bit === 0, "R4 zero fill", 32'(rd_bit), 0);

        // R10/R7: mid word flip
        inject(5, 7);
        settle();
        chk(crc_err === 1, "R7/R10 error after flip", 32'(crc_err), 1);
        read_word(1, w);
        chk(w == img_crc(5, 7), "R10/R8 flipped signature", w, img_crc(5, 7));
        chk(w != gold_m, "R5 flip changes CRC", w, ~gold_m);

        inject(5, 7);
        settle();
        chk(crc_err === 1, "R7 sticky after repair", 32'(crc_err), 1);
        read_word(1, w);
        chk(w == gold_m, "R8 repaired signature", w, gold_m);

        // R9: detection reset clears flag and memory
        @(negedge det_clk); det_rst = 1;
        repeat (2) @(negedge det_clk);
        chk(crc_err === 0, "R9 det_rst clears error", 32'(crc_err), 0);
        det_rst = 0;
        settle();
        chk(crc_err === 0, "R9 image restored", 32'(crc_err), 0);

        // boundary: last word, top bit; out-of-range address is not possible at DEPTH=16
        inject(DEPTH - 1, 31);
        settle();
        chk(crc_err === 1, "R10 last word flip", 32'(crc_err), 1);
        read_word(1, w);
        chk(w == img_crc(DEPTH - 1, 31), "R10 last word signature", w, img_crc(DEPTH - 1, 31));
        read_word(0, w);
        chk(w == gold_m, "R2 golden unchanged", w, gold_m);

        // R9: user reset clears readout
        @(negedge usr_clk); rd_shift = 0; rd_src = 0;
        @(negedge usr_clk); usr_rst = 1; rd_shift = 1;
        @(negedge usr_clk);
        chk(rd_bit === 0, "R9 usr_rst clears readout", 32'(rd_bit), 0);
        usr_rst = 0;
        repeat (4) @(negedge usr_clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule